// File: doc/BRIEF.md
# Memory-Card Command and Response Register Front-End

This block is the register-side half of a memory-card host. A processor talks to it through a small word-aligned register window. The block gathers a six-byte card command from byte-wide writes and passes the finished frame to a card engine over a valid/ready handshake. When the engine finishes, it supplies a reply, and the block stores that reply so the processor can read it back one byte per read. The block also holds three configuration words: a clock divider, a channel enable mask and a start mask. It derives the pending flags from the enable mask. A 32-bit data port turns each written word into a byte stream and packs received bytes into a word.

The stored reply is reshaped by its length. A long 16-byte reply gets a fixed header byte. A short 4-byte reply is padded with a zero byte where a check byte would sit. After a reset-type command (index 0), the next command-port write is dropped, because software uses that write only to clock the card. When the card-present input is low, both ports read as all ones and ignore writes.

Top module: `mcard_regfront`

## Requirements
- R1: The word index is `bus_addr[4:2]` with `bus_addr[1:0]` equal to 0. Index 0 is the divider, 1 the enable mask, 2 the pending flags, 3 the start mask, 4 the command byte port and 5 the data word port. Every register reads 0 after reset. The divider, enable and start registers read back the full 32-bit value last written. Any other index, or a misaligned address, reads 0. Read data appears on `bus_rdata` one clock after `bus_rd`.
- R2: Each command-port write stores `bus_wdata[7:0]`. The sixth stored byte completes a frame. In the issued frame, `cmd_index` is byte 0 bits 5:0, `cmd_arg` is bytes 1 to 4 with byte 1 in bits 31:24, and `cmd_crc` is byte 5. The byte count then restarts at 0.
- R3: `cmd_valid` rises in the clock after the sixth write. It stays high, with the frame fields unchanged, until a clock edge at which `cmd_ready` is high, and it is low after that edge.
- R4: On `rsp_done`, the reply buffer loads as follows. Position 0 takes the index of the last issued command. Positions 1 to 16 take payload bytes 0 to 15, where byte i is `rsp_payload[8i+7:8i]`. Position 17 reads 0x00. The readable length is `rsp_len`, and the read position returns to 0.
- R5: When `rsp_len` is 16, position 0 holds 0x3F instead of the index, and the readable length is 17.
- R6: When `rsp_len` is 4, position 5 holds 0x00 instead of payload byte 4, and the readable length is 6.
- R7: Each command-port read returns the byte at the read position and then advances the position by one. When the advanced position exceeds the readable length, the position returns to 0. Reads therefore visit positions 0 through the length inclusive.
- R8: After a frame with index 0 is issued, the next command-port write made while the card is present is discarded and does not count toward the next frame.
- R9: With `card_present` low, command-port reads return 0x000000FF and data-port reads return 0xFFFFFFFF. Writes to both ports leave the frame progress, the discard flag and the byte stream untouched, and command-port reads do not move the read position.
- R10: A data-port write with the card present drives `dtx_valid` for the next four clocks. `dtx_byte` carries bits 31:24, then 23:16, then 15:8, then 7:0. A new data-port write restarts the sequence.
- R11: Each `drx_valid` byte shifts into the receive word from the low end. A data-port read returns the word with the earliest of the last four bytes in bits 31:24.
- R12: Pending bit 1 equals enable bit 1 and pending bit 3 equals enable bit 3. Pending bits 0 and 2 always read 0. A write to the pending register recomputes the flags from the enable mask, whatever value is written.
- R13: If `rsp_done` and a command-port read fall in the same clock, the read returns the byte from the old buffer at the old position, and the read position ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| card_present | input | 1 | Card detected |
| bus_addr | input | 5 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| cmd_valid | output | 1 | Command frame offered to the card engine |
| cmd_ready | input | 1 | Card engine takes the frame |
| cmd_index | output | 6 | Command index of the frame |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Check byte of the frame |
| rsp_done | input | 1 | Reply available this clock |
| rsp_len | input | 5 | Reply payload length in bytes |
| rsp_payload | input | 128 | Reply bytes, byte i in bits 8i+7:8i |
| dtx_valid | output | 1 | Outgoing data byte valid |
| dtx_byte | output | 8 | Outgoing data byte |
| drx_valid | input | 1 | Incoming data byte valid |
| drx_byte | input | 8 | Incoming data byte |
| clk_div | output | 32 | Divider register value |
| en_bits | output | 4 | Enable mask bits 3:0 |
| start_bits | output | 2 | Start mask bits 1:0 |

## Verification
The command-port read and the arrival of a reply both move the read position, and they can fall in the same clock. The bench pulses `rsp_done` in the same cycle as a command-port read, at a point where the position is not at zero. It expects the byte from the old buffer at the old position. The next read must return the new reply's position 0. A second overlap checked every clock is a data-port write landing while an earlier word is still being sent. The reference byte queue is reloaded, and the output stream must switch to the new word at once.

// File: rtl/mcard_pkg.sv
package mcard_pkg;
  localparam int FRAME_BYTES = 6;
  localparam int ARG_BYTES   = 4;
  localparam int SHORT_RSP   = 4;
  localparam logic [7:0] LONG_HDR = 8'h3F;

  typedef enum logic [2:0] {
    RG_DIV   = 3'd0,
    RG_EN    = 3'd1,
    RG_PEND  = 3'd2,
    RG_START = 3'd3,
    RG_CMD   = 3'd4,
    RG_DAT   = 3'd5
  } reg_sel_e;

  // receive flags follow their enables, transmit flags stay clear
  function automatic logic [3:0] pend_from_en(input logic [3:0] en);
    return {en[3], 1'b0, en[1], 1'b0};
  endfunction
endpackage

// File: rtl/mcard_cmd_asm.sv
module mcard_cmd_asm
  import mcard_pkg::*;
#(
  parameter int PTR_W = $clog2(FRAME_BYTES)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_byte,
  input  logic        ready,
  output logic        valid,
  output logic [5:0]  index,
  output logic [31:0] arg,
  output logic [7:0]  crc
);
  logic [PTR_W-1:0] ptr_q;
  logic [5:0]       idx_q;
  logic [7:0]       arg_q [ARG_BYTES];
  logic             skip_q;
  logic             last_byte;

  assign last_byte = (ptr_q == PTR_W'(FRAME_BYTES-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      idx_q  <= '0;
      skip_q <= 1'b0;
      valid  <= 1'b0;
      index  <= '0;
      arg    <= '0;
      crc    <= '0;
      for (int i = 0; i < ARG_BYTES; i++) arg_q[i] <= '0;
    end else begin
      if (valid && ready) valid <= 1'b0;
      if (wr_en) begin
        if (skip_q) begin
          skip_q <= 1'b0;
        end else if (last_byte) begin
          ptr_q  <= '0;
          valid  <= 1'b1;
          index  <= idx_q;
          for (int i = 0; i < ARG_BYTES; i++)
            arg[(ARG_BYTES-1-i)*8 +: 8] <= arg_q[i];
          crc    <= wr_byte;
          skip_q <= (idx_q == 6'd0);
        end else begin
          if (ptr_q == '0) idx_q <= wr_byte[5:0];
          else             arg_q[2'(ptr_q - 1'b1)] <= wr_byte;
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcard_rsp_buf.sv
module mcard_rsp_buf
  import mcard_pkg::*;
#(
  parameter int RSP_MAX = 16,
  parameter int LEN_W   = $clog2(RSP_MAX+2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 done,
  input  logic [LEN_W-1:0]     len,
  input  logic [RSP_MAX*8-1:0] payload,
  input  logic [5:0]           echo_idx,
  input  logic                 rd_en,
  output logic [7:0]           rd_byte
);
  localparam int DEPTH = RSP_MAX + 2;

  logic [7:0]       buf_q [DEPTH];
  logic [LEN_W-1:0] rlen_q, ptr_q, ptr_nxt;
  logic             long_rsp, short_rsp;

  assign long_rsp  = (len == LEN_W'(RSP_MAX));
  assign short_rsp = (len == LEN_W'(SHORT_RSP));
  assign ptr_nxt   = ptr_q + 1'b1;
  assign rd_byte   = (ptr_q <= LEN_W'(DEPTH-1)) ? buf_q[ptr_q] : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) buf_q[i] <= '0;
    end else if (done) begin
      buf_q[0] <= long_rsp ? LONG_HDR : {2'b00, echo_idx};
      for (int i = 0; i < RSP_MAX; i++) buf_q[i+1] <= payload[i*8 +: 8];
      if (short_rsp) buf_q[SHORT_RSP+1] <= 8'h00;
      buf_q[DEPTH-1] <= 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rlen_q <= '0;
      ptr_q  <= '0;
    end else if (done) begin
      ptr_q  <= '0;
      if (long_rsp)       rlen_q <= LEN_W'(RSP_MAX+1);
      else if (short_rsp) rlen_q <= LEN_W'(SHORT_RSP+2);
      else                rlen_q <= len;
    end else if (rd_en) begin
      ptr_q <= (ptr_nxt > rlen_q) ? '0 : ptr_nxt;
    end
  end
endmodule

// File: rtl/mcard_dat_port.sv
module mcard_dat_port #(
  parameter int DATA_W = 32,
  parameter int NB     = DATA_W/8,
  parameter int CNT_W  = $clog2(NB+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr;
  logic [CNT_W-1:0]  tx_cnt;

  assign tx_valid = (tx_cnt != '0);
  assign tx_byte  = tx_sr[DATA_W-1 -: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr  <= '0;
      tx_cnt <= '0;
    end else if (wr_en) begin
      tx_sr  <= wdata;
      tx_cnt <= CNT_W'(NB);
    end else if (tx_cnt != '0) begin
      tx_sr  <= {tx_sr[DATA_W-9:0], 8'h00};
      tx_cnt <= tx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rx_word <= '0;
    else if (rx_valid) rx_word <= {rx_word[DATA_W-9:0], rx_byte};
  end
endmodule

// File: rtl/mcard_regfront.sv
module mcard_regfront
  import mcard_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int RSP_MAX = 16,
  localparam int LEN_W  = $clog2(RSP_MAX+2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 card_present,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [DATA_W-1:0]    bus_wdata,
  input  logic                 bus_rd,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [5:0]           cmd_index,
  output logic [31:0]          cmd_arg,
  output logic [7:0]           cmd_crc,
  input  logic                 rsp_done,
  input  logic [LEN_W-1:0]     rsp_len,
  input  logic [RSP_MAX*8-1:0] rsp_payload,
  output logic                 dtx_valid,
  output logic [7:0]           dtx_byte,
  input  logic                 drx_valid,
  input  logic [7:0]           drx_byte,
  output logic [DATA_W-1:0]    clk_div,
  output logic [3:0]           en_bits,
  output logic [1:0]           start_bits
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              sel_div, sel_en, sel_pend, sel_start, sel_cmd, sel_dat;
  logic              cmd_wr, cmd_rd, dat_wr;
  logic [DATA_W-1:0] div_q, en_q, start_q, rdata_d, rx_word;
  logic [3:0]        pend_q;
  logic [7:0]        rsp_byte;

  assign idx       = bus_addr[ADDR_W-1:2];
  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign sel_div   = aligned && (idx == IDX_W'(RG_DIV));
  assign sel_en    = aligned && (idx == IDX_W'(RG_EN));
  assign sel_pend  = aligned && (idx == IDX_W'(RG_PEND));
  assign sel_start = aligned && (idx == IDX_W'(RG_START));
  assign sel_cmd   = aligned && (idx == IDX_W'(RG_CMD));
  assign sel_dat   = aligned && (idx == IDX_W'(RG_DAT));

  assign cmd_wr = bus_wr && sel_cmd && card_present;
  assign cmd_rd = bus_rd && sel_cmd && card_present;
  assign dat_wr = bus_wr && sel_dat && card_present;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q   <= '0;
      en_q    <= '0;
      start_q <= '0;
      pend_q  <= '0;
    end else if (bus_wr) begin
      if (sel_div)   div_q   <= bus_wdata;
      if (sel_start) start_q <= bus_wdata;
      if (sel_en) begin
        en_q   <= bus_wdata;
        pend_q <= pend_from_en(bus_wdata[3:0]);
      end
      if (sel_pend)  pend_q  <= pend_from_en(en_q[3:0]);
    end
  end

  always_comb begin
    rdata_d = '0;
    if (sel_div)   rdata_d = div_q;
    if (sel_en)    rdata_d = en_q;
    if (sel_pend)  rdata_d = DATA_W'(pend_q);
    if (sel_start) rdata_d = start_q;
    if (sel_cmd)   rdata_d = card_present ? DATA_W'(rsp_byte) : DATA_W'(8'hFF);
    if (sel_dat)   rdata_d = card_present ? rx_word : '1;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  assign clk_div    = div_q;
  assign en_bits    = en_q[3:0];
  assign start_bits = start_q[1:0];

  mcard_cmd_asm u_cmd_asm (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cmd_wr),
    .wr_byte (bus_wdata[7:0]),
    .ready   (cmd_ready),
    .valid   (cmd_valid),
    .index   (cmd_index),
    .arg     (cmd_arg),
    .crc     (cmd_crc)
  );

  mcard_rsp_buf #(.RSP_MAX(RSP_MAX), .LEN_W(LEN_W)) u_rsp_buf (
    .clk      (clk),
    .rst      (rst),
    .done     (rsp_done),
    .len      (rsp_len),
    .payload  (rsp_payload),
    .echo_idx (cmd_index),
    .rd_en    (cmd_rd),
    .rd_byte  (rsp_byte)
  );

  mcard_dat_port #(.DATA_W(DATA_W)) u_dat_port (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (dat_wr),
    .wdata    (bus_wdata),
    .tx_valid (dtx_valid),
    .tx_byte  (dtx_byte),
    .rx_valid (drx_valid),
    .rx_byte  (drx_byte),
    .rx_word  (rx_word)
  );
endmodule

// File: rtl/mcard_regfront_chk.sv
module mcard_regfront_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              card_present,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        wr_top,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              dtx_valid,
  input logic [7:0]        dtx_byte
);
  logic at_pend, at_cmd, at_dat;
  assign at_pend = (bus_addr == ADDR_W'(2 << 2));
  assign at_cmd  = (bus_addr == ADDR_W'(4 << 2));
  assign at_dat  = (bus_addr == ADDR_W'(5 << 2));

  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid);

  // R3
  valid_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(bus_wr && at_cmd && card_present));

  // R9
  absent_cmd_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_cmd && !card_present |=> bus_rdata == DATA_W'(8'hFF));

  // R9
  absent_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !dtx_valid && !(bus_wr && at_dat && card_present) |=> !dtx_valid);

  // R10
  tx_first_byte_chk: assert property (@(posedge clk) disable iff (rst)
    bus_wr && at_dat && card_present |=> dtx_valid && dtx_byte == $past(wr_top));

  // R12
  pend_tx_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd && at_pend |=> !bus_rdata[0] && !bus_rdata[2]);
endmodule

bind mcard_regfront mcard_regfront_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .card_present (card_present),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .wr_top       (bus_wdata[DATA_W-1 -: 8]),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .dtx_valid    (dtx_valid),
  .dtx_byte     (dtx_byte)
);

// File: tb/mcard_regfront_bench.sv
`timescale 1ns/1ps
module mcard_regfront_bench;
  localparam int DW = 32;
  localparam int AW = 5;
  localparam int RM = 16;
  localparam int LW = $clog2(RM+2);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst = 1'b1, card_present = 1'b1;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [DW-1:0]  bus_wdata = '0, bus_rdata;
  logic           cmd_valid, cmd_ready = 1'b1;
  logic [5:0]     cmd_index;
  logic [31:0]    cmd_arg;
  logic [7:0]     cmd_crc;
  logic           rsp_done = 1'b0;
  logic [LW-1:0]  rsp_len = '0;
  logic [RM*8-1:0] rsp_payload = '0;
  logic           dtx_valid, drx_valid = 1'b0;
  logic [7:0]     dtx_byte, drx_byte = '0;
  logic [DW-1:0]  clk_div;
  logic [3:0]     en_bits;
  logic [1:0]     start_bits;

  mcard_regfront u_mcard_regfront (
    .clk(clk), .rst(rst), .card_present(card_present),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
    .rsp_done(rsp_done), .rsp_len(rsp_len), .rsp_payload(rsp_payload),
    .dtx_valid(dtx_valid), .dtx_byte(dtx_byte),
    .drx_valid(drx_valid), .drx_byte(drx_byte),
    .clk_div(clk_div), .en_bits(en_bits), .start_bits(start_bits)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  logic [7:0]  m_frame[$];
  bit          m_skip = 1'b0;
  logic [5:0]  m_last_idx = '0;
  int          m_resp[18];
  int          m_rlen = 0, m_rptr = 0;
  logic [31:0] m_rx = '0, m_div = '0, m_en = '0, m_start = '0;
  bit          m_cv = 1'b0, m_issue_now = 1'b0, m_dat_now = 1'b0;
  logic [5:0]  m_idx = '0, p_idx = '0;
  logic [31:0] m_arg = '0, p_arg = '0, m_dat_word = '0;
  logic [7:0]  m_crc = '0, p_crc = '0;
  logic [7:0]  m_txq[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_cv = 1'b0; m_issue_now = 1'b0; m_dat_now = 1'b0; m_txq.delete();
    end else begin
      if (m_cv && cmd_ready) m_cv = 1'b0;
      if (m_issue_now) begin
        m_cv = 1'b1; m_idx = p_idx; m_arg = p_arg; m_crc = p_crc; m_issue_now = 1'b0;
      end
      if (m_txq.size() > 0) void'(m_txq.pop_front());
      if (m_dat_now) begin
        m_txq.delete();
        for (int i = 3; i >= 0; i--) m_txq.push_back(m_dat_word[i*8 +: 8]);
        m_dat_now = 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R3 cmd_valid", 32'(cmd_valid), 32'(m_cv));
      if (m_cv) begin
        check("R2 cmd_index", 32'(cmd_index), 32'(m_idx));
        check("R2 cmd_arg", cmd_arg, m_arg);
        check("R2 cmd_crc", 32'(cmd_crc), 32'(m_crc));
      end
      check("R10 dtx_valid", 32'(dtx_valid), 32'(m_txq.size() > 0));
      if (m_txq.size() > 0) check("R10 dtx_byte", 32'(dtx_byte), 32'(m_txq[0]));
    end
  end

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(w << 2); bus_wr = 1'b1; bus_wdata = d;
    case (w)
      0: m_div = d;
      1: m_en = d;
      3: m_start = d;
      4: if (card_present) begin
           if (m_skip) m_skip = 1'b0;
           else begin
             m_frame.push_back(d[7:0]);
             if (m_frame.size() == 6) begin
               p_idx = m_frame[0][5:0];
               p_arg = {m_frame[1], m_frame[2], m_frame[3], m_frame[4]};
               p_crc = m_frame[5];
               m_issue_now = 1'b1;
               m_last_idx = p_idx;
               m_skip = (p_idx == 6'd0);
               m_frame.delete();
             end
           end
         end
      5: if (card_present) begin m_dat_now = 1'b1; m_dat_word = d; end
      default: ;
    endcase
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [31:0] model_read(input int w);
    logic [31:0] e;
    case (w)
      0: e = m_div;
      1: e = m_en;
      2: e = {28'd0, m_en[3], 1'b0, m_en[1], 1'b0};
      3: e = m_start;
      4: if (card_present) begin
           e = 32'(m_resp[m_rptr]);
           m_rptr++;
           if (m_rptr > m_rlen) m_rptr = 0;
         end else e = 32'h0000_00FF;
      5: e = card_present ? m_rx : 32'hFFFF_FFFF;
      default: e = '0;
    endcase
    return e;
  endfunction

  task automatic rd(input int w, input string tag);
    logic [31:0] e;
    @(negedge clk);
    bus_addr = AW'(w << 2); bus_rd = 1'b1;
    e = model_read(w);
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, e);
  endtask

  function automatic void model_load(input int len, input int seed);
    m_resp[0] = (len == 16) ? 32'h3F : 32'(m_last_idx);
    for (int i = 0; i < 16; i++) m_resp[i+1] = (seed + i*3) & 8'hFF;
    if (len == 4) m_resp[5] = 0;
    m_resp[17] = 0;
    m_rlen = (len == 16) ? 17 : (len == 4) ? 6 : len;
    m_rptr = 0;
  endfunction

  task automatic drive_rsp(input int len, input int seed);
    rsp_done = 1'b1; rsp_len = LW'(len);
    for (int i = 0; i < 16; i++) rsp_payload[i*8 +: 8] = 8'(seed + i*3);
  endtask

  task automatic rsp(input int len, input int seed);
    @(negedge clk);
    drive_rsp(len, seed);
    model_load(len, seed);
    @(negedge clk);
    rsp_done = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] b);
    @(negedge clk);
    drx_valid = 1'b1; drx_byte = b;
    m_rx = {m_rx[23:0], b};
    @(negedge clk);
    drx_valid = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b0, input logic [31:0] a, input logic [7:0] c);
    wr(4, 32'hAB00 | b0);
    for (int i = 3; i >= 0; i--) wr(4, 32'(a[i*8 +: 8]));
    wr(4, 32'(c));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state and map
    for (int w = 0; w < 6; w++) rd(w, "R1 reset value");
    rd(6, "R1 unmapped index");
    wr(0, 32'hDEAD_0017); wr(3, 32'h0000_0003); wr(1, 32'h0000_0002);
    rd(0, "R1 divider readback"); rd(3, "R1 start readback"); rd(1, "R1 enable readback");
    check("R1 clk_div port", clk_div, 32'hDEAD_0017);
    check("R1 start_bits port", 32'(start_bits), 32'h3);
    check("R1 en_bits port", 32'(en_bits), 32'h2);
    @(negedge clk); bus_addr = 5'h05; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    check("R1 misaligned reads 0", bus_rdata, 32'h0);

    // R12 pending
    rd(2, "R12 pending after en=2");
    wr(1, 32'h0000_000F); rd(2, "R12 pending after en=F");
    wr(2, 32'h0000_000F); rd(2, "R12 pending after clear write");
    wr(1, 32'h0000_0008); wr(2, 32'h0); rd(2, "R12 pending after en=8");

    // R2 frame with R4/R7 reply of length 6
    frame(8'h51, 32'h1234_5678, 8'h9B);
    check("R2 last index", 32'(cmd_index), 32'h11);
    rsp(6, 8'h20);
    for (int k = 0; k < 9; k++) rd(4, "R4 R7 reply byte len 6");

    // R5 long reply
    rsp(16, 8'h40);
    for (int k = 0; k < 19; k++) rd(4, "R5 R7 long reply byte");

    // R6 short reply
    rsp(4, 8'h60);
    for (int k = 0; k < 8; k++) rd(4, "R6 short reply byte");

    // R3 hold while not ready
    cmd_ready = 1'b0;
    frame(8'h02, 32'hCAFE_F00D, 8'h11);
    repeat (3) @(negedge clk);
    check("R3 held without ready", 32'(cmd_valid), 32'h1);
    cmd_ready = 1'b1;
    @(negedge clk);
    check("R3 dropped after ready", 32'(cmd_valid), 32'h0);

    // R8 discard after index 0
    frame(8'h40, 32'h0, 8'h95);
    wr(4, 32'hFF);
    wr(4, 32'h48); wr(4, 32'h00); wr(4, 32'h00); wr(4, 32'h01); wr(4, 32'hAA);
    check("R8 no issue after five counted bytes", 32'(cmd_valid), 32'h0);
    wr(4, 32'h87);
    check("R8 issue on sixth counted byte", 32'(cmd_valid), 32'h1);
    check("R8 index after discard", 32'(cmd_index), 32'h08);

    // R10 data transmit, including restart
    wr(5, 32'hA1B2_C3D4);
    repeat (5) @(negedge clk);
    wr(5, 32'h0102_0304);
    @(negedge clk);
    wr(5, 32'h5566_7788);
    repeat (5) @(negedge clk);

    // R11 data receive
    rx_put(8'h11); rx_put(8'h22); rx_put(8'h33); rx_put(8'h44);
    rd(5, "R11 assembled word");
    rx_put(8'h55);
    rd(5, "R11 shifted word");

    // R9 card absent, discard flag and frame progress kept
    frame(8'h40, 32'h0, 8'h95);
    card_present = 1'b0;
    wr(4, 32'h11); wr(4, 32'h22); wr(5, 32'hFFEE_DDCC);
    rd(4, "R9 absent command read"); rd(5, "R9 absent data read");
    repeat (5) @(negedge clk);
    card_present = 1'b1;
    wr(4, 32'hEE);
    frame(8'h4D, 32'h0BAD_BEEF, 8'h3C);
    check("R9 frame issued after absent period", 32'(cmd_index), 32'h0D);
    rsp(5, 8'h70);
    rd(4, "R9 R4 echo after absent period");

    // R13 reply arrives with a read in the same cycle
    rd(4, "R13 pre read");
    @(negedge clk);
    bus_addr = AW'(4 << 2); bus_rd = 1'b1;
    e = model_read(4);
    drive_rsp(6, 8'h90);
    model_load(6, 8'h90);
    @(negedge clk);
    bus_rd = 1'b0; rsp_done = 1'b0;
    check("R13 stale byte on overlap", bus_rdata, e);
    rd(4, "R13 position reset to 0");
    rd(4, "R13 next position");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule